// File: doc/BRIEF.md
# Transactional Memory Conflict Tracker

This block follows the memory footprint of one hardware transaction. Between a begin command and an end command it records every cache line that the local core touches: a read-set flag for loads, a write-set flag for stores, and the speculative store data. A small fully-associative table holds these lines. Snooped requests from other agents are compared against the table every cycle. A remote write to any tracked line, or a remote read of a line that has been written, is a conflict, and the transaction aborts.

Stores stay inside the tracker and are not seen outside it until commit. Local loads to a line that has been written return the buffered value. On end, the buffered lines leave on a drain port, one per cycle, and a done pulse comes with the commit status. On abort, for any cause, the buffered data is dropped. The status reports one bit for each abort cause and the 8-bit code of an explicit abort.

Top module: `txn_conflict_tracker`

## Requirements
- R1: After reset the tracker is idle: `tx_active` low, `snp_ready` high, no status pulse, no drain beat, no forwarded load.
- R2: `tx_begin` while idle starts a transaction with empty read and write sets, and `tx_active` is high from the next cycle. `tx_begin` during a transaction has no effect.
- R3: During a transaction, a snoop whose line matches a tracked line aborts the transaction if the snoop is a write (`snp_write`=1), or if it is a read and the line is in the write set. A snoop read of a line that has only been read does not abort. The snoop is compared against the sets as they stood at the start of its cycle. The abort shows as a one-cycle `st_valid` pulse in the next cycle, with `st_commit`=0 and `st_cause` bit 0 (conflict) set.
- R4: Matching compares the whole line address. A snoop to any other line never causes a conflict.
- R5: `tx_abort` during a transaction aborts it. The next-cycle status has `st_cause` bit 2 (explicit) set and `st_code` equal to the code supplied with the command. For every other abort, `st_code` is 0.
- R6: Each distinct line takes one of ENTRIES table slots. Further accesses to a tracked line take no new slot. An access to a new line when all slots are in use aborts with `st_cause` bit 1 (capacity).
- R7: A load (`acc_write`=0) during a transaction to a line in the write set raises `acc_fwd` in the same cycle, with `acc_rdata` holding the latest buffered data. Any other load gives `acc_fwd`=0 and `acc_rdata`=0.
- R8: Buffered stores never appear on the drain port before commit. An aborted transaction's stores are never drained, including by later transactions.
- R9: After `tx_end`, each written line appears once on the drain port, one per cycle, in the order in which the lines were first touched, carrying its final data. In the cycle after the last beat (or in the second cycle after `tx_end` when nothing was written), `drn_done` and `st_valid` pulse together with `st_commit`=1 and `st_cause`=0.
- R10: While draining, `snp_ready` is low and snoops are not compared. The drain is never aborted.
- R11: All abort causes present in the same cycle are reported together. An abort cause in the same cycle as `tx_end` wins, and nothing is drained.
- R12: `tx_end`, `tx_abort`, accesses and snoops while idle have no effect and produce no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_begin | input | 1 | Start a transaction |
| tx_end | input | 1 | Request commit |
| tx_abort | input | 1 | Explicit abort request |
| tx_abort_code | input | 8 | Code reported with an explicit abort |
| acc_valid | input | 1 | Local access valid |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_line | input | ADDR_W | Line address of the local access |
| acc_wdata | input | DATA_W | Store data |
| acc_rdata | output | DATA_W | Forwarded speculative data |
| acc_fwd | output | 1 | Load hit in the write set |
| snp_valid | input | 1 | Remote request valid |
| snp_write | input | 1 | 1 = remote write, 0 = remote read |
| snp_line | input | ADDR_W | Remote request line address |
| snp_ready | output | 1 | Low while the drain stalls snoops |
| tx_active | output | 1 | Transaction in progress |
| st_valid | output | 1 | Status pulse |
| st_commit | output | 1 | Status is a commit |
| st_cause | output | 3 | Abort causes: bit0 conflict, bit1 capacity, bit2 explicit |
| st_code | output | 8 | Explicit abort code |
| drn_valid | output | 1 | Drain beat valid |
| drn_line | output | ADDR_W | Drained line address |
| drn_data | output | DATA_W | Drained line data |
| drn_done | output | 1 | Drain finished |

## Verification
Stimulus covers remote reads and writes that hit read-only lines, written lines and neighbouring addresses. This tells the asymmetric conflict rule apart from a plain address match, and full-line matching apart from partial matching. Store sequences that revisit lines, with loads between them, show whether forwarding returns the latest data and whether drain order follows first touch rather than last write. Table fills with repeated lines, and cycles where several causes and end coincide, separate slot reuse from allocation and check how status bits combine. Snoops held across a drain, and commands issued while idle, show that the stall works and that stray inputs are ignored.

// File: rtl/txn_pkg.sv
package txn_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_RUN   = 2'd1,
        TX_DRAIN = 2'd2
    } txn_state_e;

    localparam int CAUSE_W        = 3;
    localparam int CODE_W         = 8;
    localparam int CAUSE_CONFLICT = 0;
    localparam int CAUSE_CAPACITY = 1;
    localparam int CAUSE_EXPLICIT = 2;
endpackage

// File: rtl/txn_line_match.sv
module txn_line_match #(
    parameter int N  = 4,
    parameter int AW = 16
) (
    input  logic [N-1:0][AW-1:0] lines_i,
    input  logic [N-1:0]         mask_i,
    input  logic [AW-1:0]        key_i,
    output logic [N-1:0]         hit_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_o[g] = mask_i[g] && (lines_i[g] == key_i);
    end
endmodule

// File: rtl/txn_first_set.sv
module txn_first_set #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [IW-1:0] idx_o,
    output logic          found_o
);
    always_comb begin
        idx_o   = '0;
        found_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o   = IW'(i);
                found_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker
    import txn_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_begin,
    input  logic                tx_end,
    input  logic                tx_abort,
    input  logic [CODE_W-1:0]   tx_abort_code,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [ADDR_W-1:0]   acc_line,
    input  logic [DATA_W-1:0]   acc_wdata,
    output logic [DATA_W-1:0]   acc_rdata,
    output logic                acc_fwd,
    input  logic                snp_valid,
    input  logic                snp_write,
    input  logic [ADDR_W-1:0]   snp_line,
    output logic                snp_ready,
    output logic                tx_active,
    output logic                st_valid,
    output logic                st_commit,
    output logic [CAUSE_W-1:0]  st_cause,
    output logic [CODE_W-1:0]   st_code,
    output logic                drn_valid,
    output logic [ADDR_W-1:0]   drn_line,
    output logic [DATA_W-1:0]   drn_data,
    output logic                drn_done
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        txn_state_e                      st;
        logic [ENTRIES-1:0]              rd;
        logic [ENTRIES-1:0]              wr;
        logic [ENTRIES-1:0][ADDR_W-1:0]  line;
        logic [ENTRIES-1:0][DATA_W-1:0]  data;
        logic                            stv;
        logic                            stc;
        logic [CAUSE_W-1:0]              cause;
        logic [CODE_W-1:0]               code;
        logic                            done;
    } regs_t;

    regs_t q, d;

    logic [ENTRIES-1:0] used, acc_hit, snp_hit, snp_mask;
    logic [IW-1:0]      acc_idx, free_idx, drn_idx, tgt;
    logic               acc_found, free_found, drn_found;
    logic [CAUSE_W-1:0] abort_vec;

    assign used     = q.rd | q.wr;
    assign snp_mask = snp_write ? used : q.wr;

    txn_line_match #(.N(ENTRIES), .AW(ADDR_W)) u_acc_match (
        .lines_i(q.line), .mask_i(used), .key_i(acc_line), .hit_o(acc_hit)
    );
    txn_line_match #(.N(ENTRIES), .AW(ADDR_W)) u_snp_match (
        .lines_i(q.line), .mask_i(snp_mask), .key_i(snp_line), .hit_o(snp_hit)
    );
    txn_first_set #(.N(ENTRIES)) u_acc_enc (
        .req_i(acc_hit), .idx_o(acc_idx), .found_o(acc_found)
    );
    txn_first_set #(.N(ENTRIES)) u_free_enc (
        .req_i(~used), .idx_o(free_idx), .found_o(free_found)
    );
    txn_first_set #(.N(ENTRIES)) u_drn_enc (
        .req_i(q.wr), .idx_o(drn_idx), .found_o(drn_found)
    );

    always_comb begin
        abort_vec                 = '0;
        abort_vec[CAUSE_CONFLICT] = snp_valid && (|snp_hit);
        abort_vec[CAUSE_CAPACITY] = acc_valid && !acc_found && !free_found;
        abort_vec[CAUSE_EXPLICIT] = tx_abort;
        tgt                       = acc_found ? acc_idx : free_idx;

        d       = q;
        d.stv   = 1'b0;
        d.stc   = 1'b0;
        d.cause = '0;
        d.code  = '0;
        d.done  = 1'b0;

        case (q.st)
            TX_IDLE: begin
                if (tx_begin) begin
                    d.st = TX_RUN;
                    d.rd = '0;
                    d.wr = '0;
                end
            end
            TX_RUN: begin
                if (|abort_vec) begin
                    d.st    = TX_IDLE;
                    d.stv   = 1'b1;
                    d.cause = abort_vec;
                    d.code  = tx_abort ? tx_abort_code : '0;
                end else begin
                    if (acc_valid) begin
                        d.line[tgt] = acc_line;
                        if (acc_write) begin
                            d.wr[tgt]   = 1'b1;
                            d.data[tgt] = acc_wdata;
                        end else begin
                            d.rd[tgt] = 1'b1;
                        end
                    end
                    if (tx_end) d.st = TX_DRAIN;
                end
            end
            TX_DRAIN: begin
                if (drn_found) d.wr[drn_idx] = 1'b0;
                if (d.wr == '0) begin
                    d.st   = TX_IDLE;
                    d.stv  = 1'b1;
                    d.stc  = 1'b1;
                    d.done = 1'b1;
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_active = (q.st == TX_RUN);
    assign snp_ready = (q.st != TX_DRAIN);
    assign acc_fwd   = tx_active && acc_valid && !acc_write && acc_found && q.wr[acc_idx];
    assign acc_rdata = acc_fwd ? q.data[acc_idx] : '0;
    assign drn_valid = (q.st == TX_DRAIN) && drn_found;
    assign drn_line  = drn_valid ? q.line[drn_idx] : '0;
    assign drn_data  = drn_valid ? q.data[drn_idx] : '0;
    assign st_valid  = q.stv;
    assign st_commit = q.stc;
    assign st_cause  = q.cause;
    assign st_code   = q.code;
    assign drn_done  = q.done;

    AST_CONFLICT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && snp_valid && (|snp_hit)) |=> (st_valid && !st_commit && st_cause[CAUSE_CONFLICT])); // R3
    AST_EXPLICIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && tx_abort) |=> (st_valid && st_cause[CAUSE_EXPLICIT] && st_code == $past(tx_abort_code))); // R5
    AST_CAPACITY_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && acc_valid && !acc_found && !free_found) |=> (st_valid && st_cause[CAUSE_CAPACITY])); // R6
    AST_UNIQUE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> $onehot0(acc_hit)); // R6
    AST_DONE_IS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        drn_done |-> (st_valid && st_commit && st_cause == '0)); // R9
    AST_DRAIN_NEW_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (drn_valid && $past(drn_valid)) |-> (drn_line != $past(drn_line))); // R9
    AST_DRAIN_STALLS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        drn_valid |-> !snp_ready); // R10
endmodule

// File: tb/txn_conflict_tracker_tb_top.sv
module txn_conflict_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic tx_begin, tx_end, tx_abort, acc_valid, acc_write, snp_valid, snp_write;
    logic [7:0] tx_abort_code;
    logic [AW-1:0] acc_line, snp_line;
    logic [DW-1:0] acc_wdata;
    logic [DW-1:0] acc_rdata, drn_data;
    logic [AW-1:0] drn_line;
    logic acc_fwd, snp_ready, tx_active, st_valid, st_commit, drn_valid, drn_done;
    logic [2:0] st_cause;
    logic [7:0] st_code;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txn_conflict_tracker #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_end(tx_end),
        .tx_abort(tx_abort), .tx_abort_code(tx_abort_code),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_line(acc_line),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_fwd(acc_fwd),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_line(snp_line),
        .snp_ready(snp_ready), .tx_active(tx_active), .st_valid(st_valid),
        .st_commit(st_commit), .st_cause(st_cause), .st_code(st_code),
        .drn_valid(drn_valid), .drn_line(drn_line), .drn_data(drn_data),
        .drn_done(drn_done)
    );

    typedef struct {
        logic [AW-1:0] line;
        bit            rd;
        bit            wr;
        logic [DW-1:0] data;
    } ment_t;

    ment_t mq[$];
    int    m_st;
    bit    e_stv, e_stc, e_done;
    logic [2:0] e_cause;
    logic [7:0] e_code;
    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    int    hit, dq, rem;
    bit    x_fwd, conf, cap;
    logic [DW-1:0] x_rdata;
    logic [2:0] causes;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_st = 0; e_stv = 0; e_stc = 0; e_done = 0; e_cause = 0; e_code = 0;
        end else begin
            hit = -1;
            for (int i = 0; i < mq.size(); i++) if (mq[i].line == acc_line) hit = i;
            dq = -1;
            for (int i = mq.size() - 1; i >= 0; i--) if (mq[i].wr) dq = i;
            x_fwd   = (m_st == 1) && acc_valid && !acc_write && hit >= 0 && mq[hit].wr;
            x_rdata = x_fwd ? mq[hit].data : '0;

            chk(tx_active === (m_st == 1), "tx_active", tx_active, m_st == 1);
            chk(snp_ready === (m_st != 2), "snp_ready", snp_ready, m_st != 2);
            chk(acc_fwd === x_fwd, "acc_fwd", acc_fwd, x_fwd);
            chk(acc_rdata === x_rdata, "acc_rdata", acc_rdata, x_rdata);
            chk(st_valid === e_stv, "st_valid", st_valid, e_stv);
            chk(st_commit === e_stc, "st_commit", st_commit, e_stc);
            chk(st_cause === e_cause, "st_cause", st_cause, e_cause);
            chk(st_code === e_code, "st_code", st_code, e_code);
            chk(drn_done === e_done, "drn_done", drn_done, e_done);
            chk(drn_valid === (m_st == 2 && dq >= 0), "drn_valid", drn_valid, m_st == 2 && dq >= 0);
            if (m_st == 2 && dq >= 0) begin
                chk(drn_line === mq[dq].line, "drn_line", drn_line, mq[dq].line);
                chk(drn_data === mq[dq].data, "drn_data", drn_data, mq[dq].data);
            end

            e_stv = 0; e_stc = 0; e_done = 0; e_cause = 0; e_code = 0;
            case (m_st)
                0: if (tx_begin) begin m_st = 1; mq.delete(); end
                1: begin
                    conf = 0;
                    for (int i = 0; i < mq.size(); i++)
                        if (snp_valid && mq[i].line == snp_line && (snp_write || mq[i].wr)) conf = 1;
                    cap = acc_valid && hit < 0 && mq.size() == N;
                    causes = {tx_abort, cap, conf};
                    if (causes != 0) begin
                        e_stv = 1; e_cause = causes; e_code = tx_abort ? tx_abort_code : 8'h0;
                        m_st = 0; mq.delete();
                    end else begin
                        if (acc_valid) begin
                            if (hit < 0) begin
                                mq.push_back('{line: acc_line, rd: 0, wr: 0, data: '0});
                                hit = mq.size() - 1;
                            end
                            if (acc_write) begin mq[hit].wr = 1; mq[hit].data = acc_wdata; end
                            else mq[hit].rd = 1;
                        end
                        if (tx_end) m_st = 2;
                    end
                end
                default: begin
                    if (dq >= 0) mq[dq].wr = 0;
                    rem = 0;
                    for (int i = 0; i < mq.size(); i++) if (mq[i].wr) rem++;
                    if (rem == 0) begin m_st = 0; e_stv = 1; e_stc = 1; e_done = 1; end
                end
            endcase
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
        tx_begin = 0; tx_end = 0; tx_abort = 0; tx_abort_code = 0;
        acc_valid = 0; acc_write = 0; snp_valid = 0; snp_write = 0;
    endtask
    task automatic wait_n(input int n); for (int i = 0; i < n; i++) cyc(); endtask
    task automatic beg(); tx_begin = 1; cyc(); endtask
    task automatic fin(); tx_end = 1; cyc(); endtask
    task automatic abt(input logic [7:0] c); tx_abort = 1; tx_abort_code = c; cyc(); endtask
    task automatic st(input logic [AW-1:0] l, input logic [DW-1:0] v);
        acc_valid = 1; acc_write = 1; acc_line = l; acc_wdata = v; cyc();
    endtask
    task automatic ld(input logic [AW-1:0] l);
        acc_valid = 1; acc_write = 0; acc_line = l; cyc();
    endtask
    task automatic snp(input logic [AW-1:0] l, input bit w);
        snp_valid = 1; snp_write = w; snp_line = l; cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; tx_begin = 0; tx_end = 0; tx_abort = 0; tx_abort_code = 0;
        acc_valid = 0; acc_write = 0; acc_line = 0; acc_wdata = 0;
        snp_valid = 0; snp_write = 0; snp_line = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cur_req = "R1"; wait_n(2);

        cur_req = "R2"; beg();
        cur_req = "R7"; st(16'h10, 32'h111); ld(16'h10); ld(16'h20); st(16'h30, 32'h333);
        st(16'h10, 32'h222); ld(16'h10); ld(16'h30); ld(16'h40);
        cur_req = "R9"; fin(); wait_n(5);
        beg(); ld(16'h50); fin(); wait_n(3);

        cur_req = "R3"; beg(); ld(16'h60); snp(16'h60, 0); st(16'h61, 32'h1);
        snp(16'h62, 0); snp(16'h60, 1); wait_n(2);
        beg(); st(16'h70, 32'h7); snp(16'h70, 0); wait_n(2);
        beg(); st(16'h71, 32'h8); snp(16'h71, 1); wait_n(2);
        cur_req = "R8"; beg(); ld(16'h70); fin(); wait_n(3);

        cur_req = "R4"; beg(); ld(16'h80); st(16'h82, 32'h5); snp(16'h81, 1);
        snp(16'h83, 0); snp(16'h0080 ^ 16'h8000, 1); fin(); wait_n(4);

        cur_req = "R6"; beg(); ld(16'h1); st(16'h2, 32'hA); ld(16'h3); st(16'h4, 32'hB);
        ld(16'h2); st(16'h1, 32'hC); ld(16'h5); wait_n(2);

        cur_req = "R5"; beg(); st(16'h9, 32'h9); abt(8'hA5); wait_n(2);
        cur_req = "R8"; beg(); fin(); wait_n(3);

        cur_req = "R11"; beg(); ld(16'h90);
        snp_valid = 1; snp_write = 1; snp_line = 16'h90; tx_abort = 1; tx_abort_code = 8'h3C; cyc();
        wait_n(1);
        beg(); st(16'h91, 32'h1); tx_end = 1; tx_abort = 1; tx_abort_code = 8'h11; cyc(); wait_n(3);
        beg(); st(16'h92, 32'h2); tx_end = 1; snp_valid = 1; snp_write = 0; snp_line = 16'h92; cyc();
        wait_n(3);

        cur_req = "R10"; beg(); st(16'hA1, 32'hA1); st(16'hA2, 32'hA2); st(16'hA3, 32'hA3); fin();
        for (int i = 0; i < 6; i++) begin
            snp_valid = 1; snp_write = 1; snp_line = 16'hA2; cyc();
        end
        wait_n(2);

        cur_req = "R12"; fin(); abt(8'h77); st(16'hB0, 32'h5); snp(16'hB0, 1); wait_n(2);
        beg(); st(16'hB1, 32'h6); beg(); ld(16'hB1); fin(); wait_n(3);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule